// File: doc/BRIEF.md
# Tridiagonal Forward Elimination Engine

This block runs the factorization and forward-substitution pass of the Thomas algorithm for a tridiagonal linear system. It works on one row at a time. Each row carries a sub-diagonal term L, a diagonal term D, a super-diagonal term U, a right-hand-side term X and a row index. All values are signed Q16.16 fixed point. A row marked as the first row of a new system restarts the recurrence. Every later row is eliminated against the L and X results that the engine kept from the row before it.

A restoring divider with one quotient bit per cycle forms the scaled L term. The engine drops its ready output while that divider runs. Results leave on an output bus that pulses valid once per row. The same results are also written into one of two row banks, addressed by the row index. A separate read port lets downstream logic fetch the previous complete system from the other bank while the current system is still being written. Starting a new system exchanges the roles of the two banks.

Top module: `tridiag_fwd_engine`

## Requirements
- R1: After synchronous reset, out_valid and div_err are 0, in_ready is 1, and every row of the readable bank reads back as all zero.
- R2: For a row accepted with new_matrix=1, d_out equals d_in, x_out equals x_in, and l_out equals l_in/d_in. The quotient is Q16.16, truncated toward zero, and is within 2^-10 of the real quotient.
- R3: For a row accepted with new_matrix=0, d_out = d_in − Lp·u_in. Lp is the l_out of the previous row. Products are formed in Q16.16.
- R4: For a row accepted with new_matrix=0, x_out = x_in − Lp·Xp. Xp is the x_out of the previous row.
- R5: For a row accepted with new_matrix=0, l_out = l_in / (updated d_out), within 2^-10 of the real value.
- R6: u_out repeats the accepted u_in unchanged, and out_idx repeats the accepted row_idx.
- R7: A row is accepted on a clock edge where in_valid and in_ready are both 1. in_ready stays 0 from that edge until out_valid appears. out_valid is a single-cycle pulse that is visible 49 cycles after the accepting edge (48 divide steps plus one cycle to retire). in_valid and new_matrix are ignored while in_ready is 0.
- R8: When the divisor (the updated D) is zero, l_out saturates. It becomes 0x7FFFFFFF if l_in ≥ 0 and 0x80000000 if l_in < 0, with the same timing as any other row. div_err then rises and stays 1 until reset.
- R9: Accepting a row with new_matrix=1 swaps the banks. Each result is then stored in the write bank at its row index (indices below the dimension, 5 by default). The rd_idx port reads the other bank, so it shows the previous complete system, and rows of the system in progress do not appear there until the next swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Row offered |
| in_ready | output | 1 | Engine can take a row |
| new_matrix | input | 1 | Row starts a new system, swaps banks |
| row_idx | input | 3 | Row index |
| l_in | input | 32 | Sub-diagonal term, Q16.16 |
| d_in | input | 32 | Diagonal term, Q16.16 |
| u_in | input | 32 | Super-diagonal term, Q16.16 |
| x_in | input | 32 | Right-hand-side term, Q16.16 |
| out_valid | output | 1 | Result pulse |
| out_idx | output | 3 | Row index of the result |
| l_out | output | 32 | Factorized L |
| d_out | output | 32 | Updated D |
| u_out | output | 32 | U passed through |
| x_out | output | 32 | Updated X |
| div_err | output | 1 | Sticky divide-by-zero flag |
| rd_idx | input | 3 | Read address into the previous system's bank |
| rd_l | output | 32 | Stored L at rd_idx |
| rd_d | output | 32 | Stored D at rd_idx |
| rd_u | output | 32 | Stored U at rd_idx |
| rd_x | output | 32 | Stored X at rd_idx |

## Verification
Each row's result is due exactly 49 cycles after the edge that accepted it, and nothing is due in between. The driver records the cycle count at the first falling edge after acceptance and pushes the expected result, carrying that count, into a queue. The monitor samples out_valid only on falling edges. It pops one entry per pulse, checks that the gap is 49, and reports a pulse with no queued entry as a failure. Bank contents change at the same edge as out_valid, so the bench reads them on falling edges only after the queue has drained.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

    parameter int unsigned DW = 32;
    parameter int unsigned FW = 16;
    localparam int unsigned QW = DW + FW;

    typedef logic signed [DW-1:0] fx_t;

    typedef struct packed {
        fx_t l;
        fx_t d;
        fx_t u;
        fx_t x;
    } row_t;

    typedef enum logic {ST_IDLE, ST_DIV} eng_st_t;

    localparam fx_t FX_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam fx_t FX_MIN = {1'b1, {(DW-1){1'b0}}};

    // Q-format product, floor rounding
    function automatic fx_t fx_mul(fx_t a, fx_t b);
        logic signed [2*DW-1:0] p;
        p = $signed({{DW{a[DW-1]}}, a}) * $signed({{DW{b[DW-1]}}, b});
        return p[FW+DW-1:FW];
    endfunction

    function automatic logic [DW-1:0] fx_mag(fx_t v);
        return v[DW-1] ? (~v + DW'(1)) : v;
    endfunction

    // Signed result from an unsigned quotient, clamped to the fx range
    function automatic fx_t fx_sat_quot(logic [QW-1:0] q, logic neg);
        logic hi_any;
        hi_any = |q[QW-1:DW];
        if (!neg) begin
            if (hi_any || q[DW-1]) return FX_MAX;
            return q[DW-1:0];
        end
        if (hi_any || (q[DW-1] && (|q[DW-2:0]))) return FX_MIN;
        return ~q[DW-1:0] + DW'(1);
    endfunction

endpackage

// File: rtl/tdma_seqdiv.sv
module tdma_seqdiv #(
    parameter int unsigned NW  = 48,
    parameter int unsigned DVW = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [NW-1:0]  num,
    input  logic [DVW-1:0] den,
    output logic [NW-1:0]  quo,
    output logic           done
);
    localparam int unsigned CW = $clog2(NW + 1);

    logic [DVW-1:0] rem_q;
    logic [DVW-1:0] den_q;
    logic [CW-1:0]  cnt_q;
    logic           busy_q;
    logic [DVW:0]   rem_sh;
    logic [DVW:0]   rem_sub;

    always_comb begin
        rem_sh  = {rem_q, quo[NW-1]};
        rem_sub = rem_sh - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            quo    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= CW'(NW);
                rem_q  <= '0;
                den_q  <= den;
                quo    <= num;
            end else if (busy_q) begin
                if (rem_sh >= {1'b0, den_q}) begin
                    rem_q <= rem_sub[DVW-1:0];
                    quo   <= {quo[NW-2:0], 1'b1};
                end else begin
                    rem_q <= rem_sh[DVW-1:0];
                    quo   <= {quo[NW-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tdma_row_update.sv
module tdma_row_update
    import tdma_pkg::*;
(
    input  logic            first,
    input  row_t            row,
    input  fx_t             l_prev,
    input  fx_t             x_prev,
    output fx_t             d_new,
    output fx_t             x_new,
    output logic [QW-1:0]   num_mag,
    output logic [DW-1:0]   den_mag,
    output logic            q_neg,
    output logic            den_zero
);
    always_comb begin
        if (first) begin
            d_new = row.d;
            x_new = row.x;
        end else begin
            d_new = row.d - fx_mul(l_prev, row.u);
            x_new = row.x - fx_mul(l_prev, x_prev);
        end
        num_mag  = {fx_mag(row.l), {FW{1'b0}}};
        den_mag  = fx_mag(d_new);
        q_neg    = row.l[DW-1] ^ d_new[DW-1];
        den_zero = (d_new == '0);
    end
endmodule

// File: rtl/tdma_pingpong.sv
module tdma_pingpong
    import tdma_pkg::*;
#(
    parameter int unsigned DEPTH = 5,
    parameter int unsigned AW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          swap,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  row_t          wdata,
    input  logic [AW-1:0] raddr,
    output row_t          rdata
);
    logic wsel_q;
    logic waddr_ok;
    logic raddr_ok;

    assign waddr_ok = ({1'b0, waddr} < (AW+1)'(DEPTH));
    assign raddr_ok = ({1'b0, raddr} < (AW+1)'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) wsel_q <= 1'b0;
        else if (swap) wsel_q <= ~wsel_q;
    end

    generate
        for (genvar b = 0; b < 2; b++) begin : g_bank
            row_t mem_q [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int r = 0; r < DEPTH; r++) mem_q[r] <= '0;
                end else if (we && waddr_ok && (wsel_q == 1'(b))) begin
                    mem_q[waddr] <= wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        if (!raddr_ok) rdata = '0;
        else if (wsel_q) rdata = g_bank[0].mem_q[raddr];
        else rdata = g_bank[1].mem_q[raddr];
    end
endmodule

// File: rtl/tridiag_fwd_engine.sv
module tridiag_fwd_engine
    import tdma_pkg::*;
#(
    parameter int unsigned DIM = 5,
    localparam int unsigned AW = (DIM > 1) ? $clog2(DIM) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          new_matrix,
    input  logic [AW-1:0] row_idx,
    input  logic [DW-1:0] l_in,
    input  logic [DW-1:0] d_in,
    input  logic [DW-1:0] u_in,
    input  logic [DW-1:0] x_in,
    output logic          out_valid,
    output logic [AW-1:0] out_idx,
    output logic [DW-1:0] l_out,
    output logic [DW-1:0] d_out,
    output logic [DW-1:0] u_out,
    output logic [DW-1:0] x_out,
    output logic          div_err,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_l,
    output logic [DW-1:0] rd_d,
    output logic [DW-1:0] rd_u,
    output logic [DW-1:0] rd_x
);
    localparam int unsigned LAT = QW + 1;

    eng_st_t       st_q;
    fx_t           lprev_q, xprev_q;
    row_t          pend_q;
    logic [AW-1:0] pidx_q;
    logic          pneg_q, plneg_q, pzero_q;
    row_t          res_q;
    logic [AW-1:0] ridx_q;
    logic          rvalid_q;
    logic          err_q;

    row_t          in_row;
    fx_t           d_new, x_new;
    logic [QW-1:0] num_mag;
    logic [DW-1:0] den_mag;
    logic          q_neg, den_zero;
    logic          accept;
    logic [QW-1:0] quo;
    logic          div_done;
    logic          retire;
    fx_t           l_res;
    row_t          done_row;
    row_t          rd_row;

    assign in_row   = '{l: l_in, d: d_in, u: u_in, x: x_in};
    assign in_ready = (st_q == ST_IDLE);
    assign accept   = in_valid && in_ready;
    assign retire   = (st_q == ST_DIV) && div_done;

    tdma_row_update u_upd (
        .first    (new_matrix),
        .row      (in_row),
        .l_prev   (lprev_q),
        .x_prev   (xprev_q),
        .d_new    (d_new),
        .x_new    (x_new),
        .num_mag  (num_mag),
        .den_mag  (den_mag),
        .q_neg    (q_neg),
        .den_zero (den_zero)
    );

    tdma_seqdiv #(.NW(QW), .DVW(DW)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .num   (num_mag),
        .den   (den_mag),
        .quo   (quo),
        .done  (div_done)
    );

    always_comb begin
        if (pzero_q) l_res = plneg_q ? FX_MIN : FX_MAX;
        else         l_res = fx_sat_quot(quo, pneg_q);
        done_row   = pend_q;
        done_row.l = l_res;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            lprev_q  <= '0;
            xprev_q  <= '0;
            pend_q   <= '0;
            pidx_q   <= '0;
            pneg_q   <= 1'b0;
            plneg_q  <= 1'b0;
            pzero_q  <= 1'b0;
            res_q    <= '0;
            ridx_q   <= '0;
            rvalid_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            rvalid_q <= 1'b0;
            if (accept) begin
                st_q     <= ST_DIV;
                pend_q   <= '{l: l_in, d: d_new, u: u_in, x: x_new};
                pidx_q   <= row_idx;
                pneg_q   <= q_neg;
                plneg_q  <= l_in[DW-1];
                pzero_q  <= den_zero;
            end else if (retire) begin
                st_q     <= ST_IDLE;
                res_q    <= done_row;
                ridx_q   <= pidx_q;
                rvalid_q <= 1'b1;
                lprev_q  <= l_res;
                xprev_q  <= pend_q.x;
                if (pzero_q) err_q <= 1'b1;
            end
        end
    end

    tdma_pingpong #(.DEPTH(DIM), .AW(AW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .swap  (accept && new_matrix),
        .we    (retire),
        .waddr (pidx_q),
        .wdata (done_row),
        .raddr (rd_idx),
        .rdata (rd_row)
    );

    assign out_valid = rvalid_q;
    assign out_idx   = ridx_q;
    assign l_out     = res_q.l;
    assign d_out     = res_q.d;
    assign u_out     = res_q.u;
    assign x_out     = res_q.x;
    assign div_err   = err_q;
    assign rd_l      = rd_row.l;
    assign rd_d      = rd_row.d;
    assign rd_u      = rd_row.u;
    assign rd_x      = rd_row.x;

endmodule

// File: rtl/tdma_checker.sv
module tdma_checker #(
    parameter int unsigned DW  = 32,
    parameter int unsigned AW  = 3,
    parameter int unsigned LAT = 49
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic [AW-1:0] row_idx,
    input logic [DW-1:0] u_in,
    input logic          out_valid,
    input logic [AW-1:0] out_idx,
    input logic [DW-1:0] u_out,
    input logic [DW-1:0] l_out,
    input logic          div_err
);
    localparam int unsigned CW = $clog2(LAT + 2);
    localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

    logic [CW-1:0] age_q;
    logic [DW-1:0] u_cap_q;
    logic [AW-1:0] idx_cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q     <= '0;
            u_cap_q   <= '0;
            idx_cap_q <= '0;
        end else if (in_valid && in_ready) begin
            age_q     <= '0;
            u_cap_q   <= u_in;
            idx_cap_q <= row_idx;
        end else if (age_q != {CW{1'b1}}) begin
            age_q <= age_q + CW'(1);
        end
    end

    // R7: single-cycle result pulse
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R7: result arrives at the fixed latency after acceptance
    a_r7_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (age_q == CW'(LAT)));

    // R7: engine is busy after accepting
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R7: engine is ready again with the result
    a_r7_ready_on_result: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready);

    // R6: U and index follow the accepted row
    a_r6_passthrough: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (u_out == u_cap_q && out_idx == idx_cap_q));

    // R8: error flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        div_err |=> div_err);

    // R8: error rises only with a saturated result
    a_r8_err_with_sat: assert property (@(posedge clk) disable iff (rst)
        $rose(div_err) |-> (out_valid && (l_out == SMAX || l_out == SMIN)));

endmodule

bind tridiag_fwd_engine tdma_checker #(.DW(DW), .AW(AW), .LAT(LAT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .row_idx   (row_idx),
    .u_in      (u_in),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .u_out     (u_out),
    .l_out     (l_out),
    .div_err   (div_err)
);

// File: tb/tridiag_fwd_engine_tb.sv
module tridiag_fwd_engine_tb;
    localparam int  LAT = 49;
    localparam int  DIM = 5;
    localparam real TOL = 1.0 / 1024.0;
    localparam real SC  = 65536.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        new_matrix = 1'b0;
    logic [2:0]  row_idx = '0;
    logic [31:0] l_in = '0, d_in = '0, u_in = '0, x_in = '0;
    logic        out_valid;
    logic [2:0]  out_idx;
    logic [31:0] l_out, d_out, u_out, x_out;
    logic        div_err;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_l, rd_d, rd_u, rd_x;

    always #4 clk = ~clk;

    tridiag_fwd_engine u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .new_matrix(new_matrix), .row_idx(row_idx),
        .l_in(l_in), .d_in(d_in), .u_in(u_in), .x_in(x_in),
        .out_valid(out_valid), .out_idx(out_idx),
        .l_out(l_out), .d_out(d_out), .u_out(u_out), .x_out(x_out),
        .div_err(div_err), .rd_idx(rd_idx),
        .rd_l(rd_l), .rd_d(rd_d), .rd_u(rd_u), .rd_x(rd_x)
    );

    typedef struct {
        real l; real d; real x;
        int  u; int idx;
        bit  sat; int lsat;
        bit  first;
        int  acc;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc   = 0;
    bit   finished = 0;
    real  ref_l = 0.0, ref_x = 0.0;
    real  cur_l[DIM], cur_d[DIM], cur_x[DIM];
    int   cur_u[DIM];
    real  old_l[DIM], old_d[DIM], old_x[DIM];
    int   old_u[DIM];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic real fx2r(logic [31:0] v);
        return $itor($signed(v)) / SC;
    endfunction

    function automatic int rnd_fx(real lo, real hi);
        real r;
        r = lo + (hi - lo) * $itor($urandom % 10000) / 10000.0;
        return $rtoi(r * SC);
    endfunction

    task automatic chk_real(string req, string what, logic [31:0] act, real expv);
        real a, e;
        n_chk++;
        a = fx2r(act);
        e = a - expv;
        if (e < 0.0) e = -e;
        if (e > TOL) begin
            n_bad++;
            $display("FAIL %s %s: actual %f expected %f", req, what, a, expv);
        end
    endtask

    task automatic chk_int(string req, string what, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // monitor: pops one expected row per result pulse
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R7 unexpected result: actual 1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk_int("R7", "latency", cyc - e.acc, LAT);
                chk_int("R6", "u passthrough", $signed(u_out), e.u);
                chk_int("R6", "index", int'(out_idx), e.idx);
                if (e.sat) begin
                    chk_int("R8", "saturated l", $signed(l_out), e.lsat);
                    chk_int("R8", "error flag", int'(div_err), 1);
                end else if (e.first) begin
                    chk_real("R2", "first l", l_out, e.l);
                end else begin
                    chk_real("R5", "scaled l", l_out, e.l);
                end
                chk_real(e.first ? "R2" : "R3", "d", d_out, e.d);
                chk_real(e.first ? "R2" : "R4", "x", x_out, e.x);
            end
        end
    end

    task automatic send_row(bit first, int idx, int l, int d, int u, int x, int junk);
        exp_t e;
        real lr, dr, ur, xr, dn, xn, ln;
        lr = $itor(l) / SC; dr = $itor(d) / SC; ur = $itor(u) / SC; xr = $itor(x) / SC;
        if (first) begin
            for (int k = 0; k < DIM; k++) begin
                old_l[k] = cur_l[k]; old_d[k] = cur_d[k];
                old_x[k] = cur_x[k]; old_u[k] = cur_u[k];
            end
            dn = dr; xn = xr;
        end else begin
            dn = dr - ref_l * ur;
            xn = xr - ref_l * ref_x;
        end
        e.sat = first && (d == 0);
        e.lsat = (l < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
        ln = e.sat ? $itor(e.lsat) / SC : lr / dn;
        e.l = ln; e.d = dn; e.x = xn; e.u = u; e.idx = idx; e.first = first;
        ref_l = ln; ref_x = xn;
        cur_l[idx] = ln; cur_d[idx] = dn; cur_x[idx] = xn; cur_u[idx] = u;

        @(negedge clk);
        in_valid = 1'b1; new_matrix = first; row_idx = 3'(idx);
        l_in = l; d_in = d; u_in = u; x_in = x;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        e.acc = cyc;
        sb.push_back(e);
        in_valid = 1'b0; new_matrix = 1'b0;
        // R7: offers made while busy must be ignored
        for (int j = 0; j < junk; j++) begin
            in_valid = 1'b1; new_matrix = 1'b1;
            l_in = 32'h1234_5678; d_in = 32'h0; x_in = 32'h7777_0000;
            chk_int("R7", "ready low while busy", int'(in_ready), 0);
            @(negedge clk);
        end
        in_valid = 1'b0; new_matrix = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_matrix(int junk_row);
        for (int i = 0; i < DIM; i++) begin
            send_row(i == 0, i, rnd_fx(-1.0, 1.0), rnd_fx(4.0, 8.0),
                     rnd_fx(-1.0, 1.0), rnd_fx(-4.0, 4.0), (i == junk_row) ? 6 : 0);
        end
    endtask

    // R9: the read port shows the previous complete system
    task automatic check_bank();
        for (int i = 0; i < DIM; i++) begin
            rd_idx = 3'(i);
            @(negedge clk);
            chk_real("R9", "bank l", rd_l, old_l[i]);
            chk_real("R9", "bank d", rd_d, old_d[i]);
            chk_real("R9", "bank x", rd_x, old_x[i]);
            chk_int("R9", "bank u", $signed(rd_u), old_u[i]);
        end
    endtask

    initial begin
        for (int k = 0; k < DIM; k++) begin
            cur_l[k] = 0.0; cur_d[k] = 0.0; cur_x[k] = 0.0; cur_u[k] = 0;
            old_l[k] = 0.0; old_d[k] = 0.0; old_x[k] = 0.0; old_u[k] = 0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_int("R1", "out_valid", int'(out_valid), 0);
        chk_int("R1", "in_ready", int'(in_ready), 1);
        chk_int("R1", "div_err", int'(div_err), 0);
        for (int i = 0; i < DIM; i++) begin
            rd_idx = 3'(i);
            @(negedge clk);
            chk_int("R1", "bank zero", int'(rd_l | rd_d | rd_u | rd_x), 0);
        end

        send_matrix(1);      // system A, busy offers on row 1
        check_bank();        // still empty: A not yet visible
        send_matrix(3);      // system B
        check_bank();        // shows A
        send_matrix(-1);     // system C
        check_bank();        // shows B
        send_matrix(0);      // system D
        check_bank();        // shows C

        // R8: zero divisor, positive then negative numerator
        send_row(1, 0, rnd_fx(0.1, 1.0), 0, rnd_fx(-1.0, 1.0), rnd_fx(-4.0, 4.0), 0);
        send_row(1, 0, rnd_fx(-1.0, -0.1), 0, rnd_fx(-1.0, 1.0), rnd_fx(-4.0, 4.0), 0);
        send_row(1, 0, rnd_fx(-1.0, 1.0), rnd_fx(4.0, 8.0), rnd_fx(-1.0, 1.0), rnd_fx(-4.0, 4.0), 0);
        chk_int("R8", "sticky div_err", int'(div_err), 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        if (!finished && cyc > 150000) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule